// File: doc/BRIEF.md
# Descriptor Queue Manager with Completion Interrupt

This block keeps 64 hardware queues of descriptor pointers for a packet DMA engine. A producer (software or a DMA channel) pushes a descriptor by presenting a queue number and one 32-bit word. The upper 27 bits of the word hold a descriptor address that is 32-byte aligned. The lower 5 bits hold a size code. A consumer pops a queue by number and receives the words of that queue in first-in, first-out order, exactly as they were pushed.

All queues share one pool of 512 storage nodes. Each queue is a linked list through that pool, and a free list holds the unused nodes. A pending vector carries one bit per queue. A bit is set while its queue holds anything, so a handler can read bits 24 to 27 to find which completion queue has work. Queues 24 and 25 (transmit completions) and 26 and 27 (receive completions) drive a level interrupt. That interrupt is ORed with the parent controller's own interrupt onto one output line, and it has no enable or mask. Producers that want no interrupt send their completions to any other queue.

Top module: `dqm_top`

## Requirements
- R1: Each of the 64 queues returns its pushed words in push order, with every one of the 32 bits unchanged (pointer in bits 31:5, size code in bits 4:0).
- R2: `pop_word` and `pop_hit` update on the clock edge that accepts a pop request and hold their value when there is no request. A pop of an empty queue returns 32'h0 with `pop_hit` low.
- R3: `pend[n]` is 1 exactly when queue n holds at least one descriptor, and it reflects a push or pop from the edge that accepts it.
- R4: `irq_out` equals `parent_irq` OR (any of queues 24, 25, 26, 27 non-empty). No mask or enable exists, and no other queue affects it.
- R5: A queue holds at most 16 descriptors. A push to a full queue is dropped, the queue's contents stay the same, and `overflow` is set.
- R6: The queues together hold at most 512 descriptors. A push while 512 are held is dropped and sets `overflow`.
- R7: A push and a pop in the same cycle are both honoured, and the pop is served first. A push to a full queue that is being popped is accepted. A push to an empty queue that is being popped lands, and the pop returns 32'h0.
- R8: While `rst_n` is low at a clock edge, all queues become empty, `pend` and `overflow` go to 0, `pop_word` goes to 0, and `irq_out` follows `parent_irq`.
- R9: `overflow` stays set once set, until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Push request this cycle |
| push_qid | input | 6 | Queue number for the push |
| push_word | input | 32 | Descriptor address (31:5) and size code (4:0) |
| pop_valid | input | 1 | Pop request this cycle |
| pop_qid | input | 6 | Queue number for the pop |
| pop_word | output | 32 | Word returned by the last pop, 0 if that queue was empty |
| pop_hit | output | 1 | Last pop found a descriptor |
| pend | output | 64 | One bit per queue, set while the queue is non-empty |
| parent_irq | input | 1 | Parent controller's interrupt, merged into irq_out |
| irq_out | output | 1 | Shared interrupt line |
| overflow | output | 1 | Sticky flag for a dropped push |

## Verification
Several properties are checked on every cycle by the assertions. No queue count goes above 16, the pool count never goes above 512, a pop is never taken from an empty list, and an empty-queue pop returns zero. The assertions also check that a full queue with no pop on it forces the overflow flag, that the flag never clears, and that a non-empty completion queue always drives the interrupt. Other behaviour needs the bench's scenarios against its reference queues. These are the FIFO order and integrity of the words, the 512-node pool limit that is reached by filling 32 queues, the ordering when a push and a pop fall in the same cycle, and the fact that the interrupt stays low for the other 60 queues.

// File: rtl/dqm_pkg.sv
`timescale 1ns/1ps
// dqm_pkg: shared word type and push-word field positions for the
// descriptor queue manager. Assumes 32-byte aligned descriptors.
package dqm_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned SIZE_W   = 5;              // size code in low bits
    localparam int unsigned ADDR_LSB = SIZE_W;         // address starts above it
    typedef logic [WORD_W-1:0] dq_word_t;
endpackage

// File: rtl/dqm_node_store.sv
`timescale 1ns/1ps
// dqm_node_store: shared node pool. Each node holds a descriptor word and a
// link to the next node. Reads are asynchronous and writes are synchronous.
// Assumes at most one link write and one data write per cycle. The contents
// need no reset, because the lists and the free list define what is valid.
module dqm_node_store
    import dqm_pkg::*;
#(
    parameter int unsigned POOL = 512,
    localparam int unsigned AW  = $clog2(POOL)
) (
    input  logic           clk,
    input  logic           data_we,
    input  logic [AW-1:0]  data_addr,
    input  dq_word_t       data_wr,
    input  logic           link_we,
    input  logic [AW-1:0]  link_addr,
    input  logic [AW-1:0]  link_wr,
    input  logic [AW-1:0]  rd_a_addr,
    output dq_word_t       rd_a_data,
    output logic [AW-1:0]  rd_a_link,
    input  logic [AW-1:0]  rd_b_addr,
    output logic [AW-1:0]  rd_b_link
);
    dq_word_t      data_mem [POOL];
    logic [AW-1:0] link_mem [POOL];

    // Write the descriptor word of a newly linked node.
    always_ff @(posedge clk) begin
        if (data_we) data_mem[data_addr] <= data_wr;
    end

    // Write one list link (queue tail link or free-list link).
    always_ff @(posedge clk) begin
        if (link_we) link_mem[link_addr] <= link_wr;
    end

    // Port a serves the popped head; port b serves the free-list head.
    assign rd_a_data = data_mem[rd_a_addr];
    assign rd_a_link = link_mem[rd_a_addr];
    assign rd_b_link = link_mem[rd_b_addr];
endmodule

// File: rtl/dqm_alloc.sv
`timescale 1ns/1ps
// dqm_alloc: node allocator. It hands out never-used nodes in order through a
// fresh counter, and after that reuses nodes from a linked free list. This
// keeps the free list from needing a reset walk over the pool. Assumes take
// and give never happen together (the top recycles a popped node straight
// into a same-cycle push instead).
module dqm_alloc #(
    parameter int unsigned POOL = 512,
    localparam int unsigned AW  = $clog2(POOL),
    localparam int unsigned UW  = $clog2(POOL + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           take,
    input  logic           give,
    input  logic [AW-1:0]  give_node,
    input  logic [AW-1:0]  free_next,
    output logic [AW-1:0]  free_head,
    output logic [AW-1:0]  alloc_node,
    output logic           has_room
);
    logic [UW-1:0] fresh_cnt;
    logic [UW-1:0] used_cnt;
    logic          fresh_left;

    assign fresh_left = fresh_cnt < UW'(POOL);
    assign alloc_node = fresh_left ? fresh_cnt[AW-1:0] : free_head;
    assign has_room   = used_cnt < UW'(POOL);

    // Track the nodes in use and move the fresh counter or the free-list head.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fresh_cnt <= '0;
            used_cnt  <= '0;
            free_head <= '0;
        end else if (take) begin
            used_cnt <= used_cnt + 1'b1;
            if (fresh_left) fresh_cnt <= fresh_cnt + 1'b1;
            else            free_head <= free_next;
        end else if (give) begin
            used_cnt  <= used_cnt - 1'b1;
            free_head <= give_node;
        end
    end

    AST_POOL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        used_cnt <= UW'(POOL)) else $error("pool count exceeded");         // R6
    AST_TAKE_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> has_room) else $error("allocation with no free node");   // R6
    AST_TAKE_GIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(take && give)) else $error("take and give together");           // R7
endmodule

// File: rtl/dqm_queue_table.sv
`timescale 1ns/1ps
// dqm_queue_table: head, tail and count for every queue, plus the pending
// vector. Assumes pop_en is asserted only for a non-empty queue and push_en
// only for an accepted push. A pop is applied before a push to the same queue.
module dqm_queue_table #(
    parameter int unsigned NUM_Q   = 64,
    parameter int unsigned Q_DEPTH = 16,
    parameter int unsigned AW      = 9,
    localparam int unsigned QW     = $clog2(NUM_Q),
    localparam int unsigned CW     = $clog2(Q_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop_en,
    input  logic [QW-1:0]    pop_q,
    input  logic [AW-1:0]    pop_next,
    input  logic             push_en,
    input  logic [QW-1:0]    push_q,
    input  logic [AW-1:0]    push_node,
    output logic [AW-1:0]    pop_head,
    output logic [CW-1:0]    pop_cnt,
    output logic [AW-1:0]    push_tail,
    output logic [CW-1:0]    push_cnt,
    output logic [NUM_Q-1:0] pend
);
    logic [NUM_Q*AW-1:0] head_flat;
    logic [NUM_Q*AW-1:0] tail_flat;
    logic [NUM_Q*CW-1:0] cnt_flat;

    for (genvar g = 0; g < NUM_Q; g++) begin : g_q
        logic [AW-1:0] head_q;
        logic [AW-1:0] tail_q;
        logic [CW-1:0] cnt_q;
        logic          hit_pop;
        logic          hit_push;

        assign hit_pop  = pop_en  && (pop_q  == QW'(g));
        assign hit_push = push_en && (push_q == QW'(g));

        // Update this queue's count, head and tail for a pop and/or push.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q  <= '0;
                head_q <= '0;
                tail_q <= '0;
            end else begin
                if (hit_pop && !hit_push)      cnt_q <= cnt_q - 1'b1;
                else if (hit_push && !hit_pop) cnt_q <= cnt_q + 1'b1;
                if (hit_push) tail_q <= push_node;
                if (hit_pop)
                    head_q <= (cnt_q == CW'(1)) ? push_node : pop_next;
                else if (hit_push && cnt_q == '0)
                    head_q <= push_node;
            end
        end

        assign head_flat[g*AW +: AW] = head_q;
        assign tail_flat[g*AW +: AW] = tail_q;
        assign cnt_flat[g*CW +: CW]  = cnt_q;
        assign pend[g]               = (cnt_q != '0);

        AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= CW'(Q_DEPTH)) else $error("queue depth exceeded");   // R5
        AST_NO_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
            hit_pop |-> cnt_q != '0) else $error("pop of empty list");     // R2
    end

    assign pop_head  = head_flat[pop_q*AW +: AW];
    assign pop_cnt   = cnt_flat[pop_q*CW +: CW];
    assign push_tail = tail_flat[push_q*AW +: AW];
    assign push_cnt  = cnt_flat[push_q*CW +: CW];
endmodule

// File: rtl/dqm_top.sv
`timescale 1ns/1ps
// dqm_top: descriptor queue manager. It holds NUM_Q FIFO queues of 32-bit
// descriptor words as linked lists in a shared node pool. A pop result is
// registered. The pending vector and a completion interrupt that cannot be
// masked are driven from the queue counts. Assumes one push and one pop
// request per cycle at most. A popped node is recycled into a push in the
// same cycle.
module dqm_top
    import dqm_pkg::*;
#(
    parameter int unsigned NUM_Q    = 64,
    parameter int unsigned Q_DEPTH  = 16,
    parameter int unsigned POOL     = 512,
    parameter int unsigned CPL_BASE = 24,
    parameter int unsigned CPL_NUM  = 4,
    localparam int unsigned QW      = $clog2(NUM_Q),
    localparam int unsigned AW      = $clog2(POOL),
    localparam int unsigned CW      = $clog2(Q_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [QW-1:0]    push_qid,
    input  logic [31:0]      push_word,
    input  logic             pop_valid,
    input  logic [QW-1:0]    pop_qid,
    output logic [31:0]      pop_word,
    output logic             pop_hit,
    output logic [NUM_Q-1:0] pend,
    input  logic             parent_irq,
    output logic             irq_out,
    output logic             overflow
);
    logic [AW-1:0] pop_head, pop_next, push_tail, push_node;
    logic [AW-1:0] free_head, free_next, alloc_node;
    logic [CW-1:0] pop_cnt, push_cnt, push_cnt_eff;
    logic          pop_fire, push_ok, has_room, take, give;
    logic          link_we;
    logic [AW-1:0] link_addr, link_wr;
    dq_word_t      head_word;

    // Decide whether the pop and the push go ahead; the pop is applied first.
    always_comb begin
        pop_fire     = pop_valid && (pop_cnt != '0);
        push_cnt_eff = push_cnt - CW'(pop_fire && (pop_qid == push_qid));
        push_ok      = push_valid && (push_cnt_eff < CW'(Q_DEPTH))
                       && (pop_fire || has_room);
        push_node    = pop_fire ? pop_head : alloc_node;
        take         = push_ok && !pop_fire;
        give         = pop_fire && !push_ok;
    end

    // Choose the single link write of the cycle: free-list return or tail link.
    always_comb begin
        link_we   = 1'b0;
        link_addr = push_tail;
        link_wr   = push_node;
        if (give) begin
            link_we   = 1'b1;
            link_addr = pop_head;
            link_wr   = free_head;
        end else if (push_ok && push_cnt_eff != '0) begin
            link_we   = 1'b1;
        end
    end

    dqm_queue_table #(.NUM_Q(NUM_Q), .Q_DEPTH(Q_DEPTH), .AW(AW)) u_table (
        .clk(clk), .rst_n(rst_n),
        .pop_en(pop_fire), .pop_q(pop_qid), .pop_next(pop_next),
        .push_en(push_ok), .push_q(push_qid), .push_node(push_node),
        .pop_head(pop_head), .pop_cnt(pop_cnt),
        .push_tail(push_tail), .push_cnt(push_cnt), .pend(pend)
    );

    dqm_alloc #(.POOL(POOL)) u_alloc (
        .clk(clk), .rst_n(rst_n), .take(take), .give(give),
        .give_node(pop_head), .free_next(free_next), .free_head(free_head),
        .alloc_node(alloc_node), .has_room(has_room)
    );

    dqm_node_store #(.POOL(POOL)) u_store (
        .clk(clk),
        .data_we(push_ok), .data_addr(push_node), .data_wr(push_word),
        .link_we(link_we), .link_addr(link_addr), .link_wr(link_wr),
        .rd_a_addr(pop_head), .rd_a_data(head_word), .rd_a_link(pop_next),
        .rd_b_addr(free_head), .rd_b_link(free_next)
    );

    // Register the pop result; an empty queue yields the all-zero word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_word <= '0;
            pop_hit  <= 1'b0;
        end else if (pop_valid) begin
            pop_word <= pop_fire ? head_word : '0;
            pop_hit  <= pop_fire;
        end
    end

    // Sticky record of any dropped push.
    always_ff @(posedge clk) begin
        if (!rst_n)                      overflow <= 1'b0;
        else if (push_valid && !push_ok) overflow <= 1'b1;
    end

    // Completion queues raise the shared line; there is no mask.
    assign irq_out = parent_irq | (|pend[CPL_BASE +: CPL_NUM]);

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow) else $error("overflow cleared");              // R9
    AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid && !pend[pop_qid] |=> (pop_word == '0) && !pop_hit)
        else $error("empty pop returned data");                              // R2
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && push_cnt == CW'(Q_DEPTH)
        && !(pop_valid && pop_qid == push_qid) |=> overflow)
        else $error("full push not flagged");                                // R5
    AST_POP_MAKES_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && pop_valid && push_qid == pop_qid
        && push_cnt == CW'(Q_DEPTH) |=> overflow == $past(overflow))
        else $error("push on popped full queue dropped");                    // R7
    AST_IRQ_CPL: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[CPL_BASE +: CPL_NUM] != '0) |-> irq_out)
        else $error("completion queue without interrupt");                   // R4
endmodule

// File: tb/tb_dqm_top.sv
`timescale 1ns/1ps
// tb_dqm_top: directed corners plus seeded random traffic, checked against
// reference queues that the bench keeps.
module tb_dqm_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0, pop_valid = 1'b0, parent_irq = 1'b0;
    logic [5:0]  push_qid = '0, pop_qid = '0;
    logic [31:0] push_word = '0;
    logic [31:0] pop_word;
    logic        pop_hit, irq_out, overflow;
    logic [63:0] pend;

    int unsigned n_chk = 0, n_bad = 0;
    logic [31:0] mq [64][$];
    int          total = 0;
    logic [31:0] exp_word = '0;
    logic        exp_hit = 1'b0, exp_ovf = 1'b0;

    always #5 clk = ~clk;

    dqm_top dut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_qid(push_qid),
        .push_word(push_word), .pop_valid(pop_valid), .pop_qid(pop_qid),
        .pop_word(pop_word), .pop_hit(pop_hit), .pend(pend),
        .parent_irq(parent_irq), .irq_out(irq_out), .overflow(overflow)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_pend();
        logic [63:0] p = '0;
        for (int q = 0; q < 64; q++) p[q] = (mq[q].size() != 0);
        return p;
    endfunction

    function automatic logic exp_irq(input logic par);
        logic [63:0] p = exp_pend();
        return par | (|p[27:24]);
    endfunction

    // One cycle of stimulus, reference update, and checks after the edge.
    task automatic step(input logic pv, input logic [5:0] pq, input logic [31:0] pw,
                        input logic ov, input logic [5:0] oq, input logic par,
                        input string tag);
        @(negedge clk);
        push_valid = pv; push_qid = pq; push_word = pw;
        pop_valid = ov; pop_qid = oq; parent_irq = par;
        if (ov) begin
            if (mq[oq].size() != 0) begin
                exp_word = mq[oq].pop_front(); exp_hit = 1'b1; total--;
            end else begin
                exp_word = '0; exp_hit = 1'b0;
            end
        end
        if (pv) begin
            if (mq[pq].size() < 16 && total < 512) begin
                mq[pq].push_back(pw); total++;
            end else exp_ovf = 1'b1;
        end
        @(posedge clk); #1;
        chk({tag, " R2 pop_word"}, 64'(pop_word), 64'(exp_word));
        chk({tag, " R2 pop_hit"}, 64'(pop_hit), 64'(exp_hit));
        chk({tag, " R3 pend"}, pend, exp_pend());
        chk({tag, " R4 irq_out"}, 64'(irq_out), 64'(exp_irq(par)));
        chk({tag, " R9 overflow"}, 64'(overflow), 64'(exp_ovf));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; push_valid = 1'b0; pop_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        for (int q = 0; q < 64; q++) mq[q].delete();
        total = 0; exp_word = '0; exp_hit = 1'b0; exp_ovf = 1'b0;
        chk("R8 pend", pend, 64'h0);
        chk("R8 overflow", 64'(overflow), 64'h0);
        chk("R8 pop_word", 64'(pop_word), 64'h0);
        chk("R8 irq_out", 64'(irq_out), 64'(parent_irq));
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [31:0] mkword(input int a, input int s);
        return {27'(a), 5'(s)};
    endfunction

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd2024));
        parent_irq = 1'b1;
        do_reset();
        parent_irq = 1'b0;

        // R1/R5: fill queue 5 beyond depth, then drain in order.
        for (int i = 0; i < 17; i++) step(1, 6'd5, mkword(i * 7 + 1, i), 0, 0, 0, "R5 fill");
        chk("R5 overflow after 17th push", 64'(overflow), 64'h1);
        for (int i = 0; i < 16; i++) begin
            step(0, 0, 0, 1, 6'd5, 0, "R1 drain");
            chk("R1 fifo word", 64'(pop_word), 64'(mkword(i * 7 + 1, i)));
        end
        step(0, 0, 0, 1, 6'd5, 0, "R2 empty pop");
        chk("R2 empty pop zero", 64'(pop_word), 64'h0);

        // R4: a non-completion queue stays quiet, completion queue 26 raises it.
        step(1, 6'd10, mkword(3, 1), 0, 0, 0, "R4 q10");
        chk("R4 q10 no irq", 64'(irq_out), 64'h0);
        step(1, 6'd26, mkword(4, 2), 0, 0, 0, "R4 q26");
        chk("R4 q26 irq", 64'(irq_out), 64'h1);
        step(0, 0, 0, 1, 6'd26, 0, "R4 q26 pop");
        chk("R4 irq drops", 64'(irq_out), 64'h0);
        step(0, 0, 0, 0, 0, 1, "R4 parent");
        step(0, 0, 0, 1, 6'd10, 0, "R4 clean");

        // R7: same-cycle push and pop on empty and on full queues.
        do_reset();
        step(1, 6'd7, mkword(9, 3), 1, 6'd7, 0, "R7 empty both");
        chk("R7 empty pop zero", 64'(pop_hit), 64'h0);
        chk("R7 push landed", 64'(pend[7]), 64'h1);
        for (int i = 0; i < 15; i++) step(1, 6'd7, mkword(20 + i, i), 0, 0, 0, "R7 fill");
        step(1, 6'd7, mkword(99, 31), 1, 6'd7, 0, "R7 full both");
        chk("R7 full push kept overflow low", 64'(overflow), 64'h0);
        chk("R7 pop first", 64'(pop_word), 64'(mkword(9, 3)));

        // R6: fill the 512-node pool over queues 32..63, then one more push.
        do_reset();
        for (int q = 32; q < 64; q++)
            for (int i = 0; i < 16; i++) step(1, 6'(q), mkword(q * 64 + i, q), 0, 0, 0, "R6 fill");
        chk("R6 no overflow at 512", 64'(overflow), 64'h0);
        step(1, 6'd0, mkword(1, 1), 0, 0, 0, "R6 exhausted");
        chk("R6 overflow on exhaust", 64'(overflow), 64'h1);
        chk("R6 queue 0 empty", 64'(pend[0]), 64'h0);
        step(1, 6'd0, mkword(2, 2), 1, 6'd40, 0, "R6 recycle");
        chk("R6 recycled push", 64'(pend[0]), 64'h1);

        // Random traffic on a few ordinary and completion queues.
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            logic [5:0] pq, oq;
            r = $urandom();
            pq = r[3] ? 6'(24 + r[1:0]) : 6'(r[1:0]);
            oq = r[7] ? 6'(24 + r[5:4]) : 6'(r[5:4]);
            step(r[10:8] < 3'd5, pq, $urandom(), r[13:11] < 3'd4, oq, r[20:16] == 5'd0, "R1 rand");
        end
        do_reset();
        chk("R9 overflow cleared only by reset", 64'(overflow), 64'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule